// File: doc/BRIEF.md
# Passive Serial Configuration Loader

This block programs a target FPGA through its passive serial load path. A host hands it a byte count and a clock divider, pulses `start`, and then feeds the bitstream through a valid/ready byte stream. The block first pulls the active-low configuration request line low for a fixed number of microseconds. It then waits for the target to report that it is ready. After that it serializes every byte, least-significant bit first, on a data line and a configuration clock. When the last bit has gone out, it waits a fixed settling time and reads the target's completion line.

The outcome is reported on three exclusive flags. `busy` is high during a run. `done` means the target accepted the image. `error` means the target never became ready, or it did not signal completion. All microsecond intervals are cycle counts derived from a clock-frequency parameter. The configuration clock's half-period is set per run by the host. The target's two inputs pass through synchronizers before the sequencer uses them.

Top module: `ps_cfg_master`

## Requirements
- R1: While reset is applied and after it is released, with no start: `cfg_req_n`=1, `cfg_clk`=0, `cfg_dat`=0, `s_ready`=0, `busy`=0, `done`=0, `error`=0.
- R2: A `start` seen while idle drives `cfg_req_n` low for exactly PULSE_US*CLK_MHZ cycles, then high again. No configuration clock edge occurs during that pulse.
- R3: After the pulse, data transfer begins only once the synchronized `tgt_status` is high. If it goes high in the same cycle the ready timeout expires, readiness wins.
- R4: If the synchronized `tgt_status` has not been high within STATUS_TO_US*CLK_MHZ cycles after the pulse, the run ends with `error`=1 and `done`=0. No `cfg_clk` edge occurs and `s_ready` is never raised.
- R5: Each byte produces exactly eight rising edges of `cfg_clk`. `cfg_dat` carries bit 0 first and bit 7 last. Bytes go out in stream order, and exactly `byte_total` bytes are sent.
- R6: `cfg_dat` changes only while `cfg_clk` is low. Each high phase and each in-byte low phase of `cfg_clk` lasts `half_div`+1 system cycles.
- R7: `s_ready` is high only while the block waits for the next byte. Each cycle with `s_valid` and `s_ready` both high consumes one byte. No byte is accepted after `byte_total` bytes.
- R8: After the last bit, the block waits DONE_US*CLK_MHZ cycles and then reads the synchronized `tgt_done`. A high level ends the run with `done`=1; a low level ends it with `error`=1.
- R9: With `byte_total`=0 the block skips the data phase. After readiness it goes straight to the completion wait.
- R10: A `start` arriving while `busy` is high has no effect on the run in progress.
- R11: `done` and `error` hold their value while idle and are cleared on the cycle after an accepted `start`. At most one of `busy`, `done` and `error` is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a configuration run (accepted only when idle) |
| byte_total | input | CNT_W | Number of bitstream bytes for this run |
| half_div | input | DIV_W | Configuration clock half-period minus one, in system cycles |
| s_valid | input | 1 | Byte stream valid |
| s_data | input | 8 | Byte stream data |
| s_ready | output | 1 | Byte stream ready |
| cfg_req_n | output | 1 | Active-low configuration request to target |
| cfg_clk | output | 1 | Configuration clock to target |
| cfg_dat | output | 1 | Serial configuration data to target |
| tgt_status | input | 1 | Target ready indication (high = ready) |
| tgt_done | input | 1 | Target configuration-complete indication |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run succeeded |
| error | output | 1 | Last run failed |

## Verification
Two functions can fall in the same cycle: the synchronized ready indication first becoming high, and the ready timeout reaching zero. The bench raises `tgt_status` a counted number of cycles after the pulse ends. One setting lands the synchronized level exactly on the timeout's last cycle, and another lands it one cycle later. The first run must proceed to transfer the byte and the second must end in `error` with no clock edges. A second coincidence is a `start` landing mid-transfer. It is judged by the captured bitstream and the final flags staying those of the undisturbed run.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_PULSE     = 3'd1,
    ST_WAIT_ST   = 3'd2,
    ST_LOAD      = 3'd3,
    ST_SHIFT     = 3'd4,
    ST_WAIT_DONE = 3'd5
  } cfg_state_e;
endpackage

// File: rtl/ps_sync.sv
module ps_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff_q;
  logic [STAGES-1:0] ff_d;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign ff_d[i] = d;
    end else begin : g_next
      assign ff_d[i] = ff_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= ff_d;
  end

  assign q = ff_q[STAGES-1];
endmodule

// File: rtl/ps_us_timer.sv
module ps_us_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

  // R2: the interval counter steps down by one each idle cycle
  p_timer_step_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/ps_bit_shifter.sv
module ps_bit_shifter #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             load,
  input  logic [7:0]       din,
  input  logic [DIV_W-1:0] half_div,
  output logic             sclk,
  output logic             sdat,
  output logic             active,
  output logic             last
);
  logic [7:0]       sr_q, sr_d;
  logic [2:0]       bi_q, bi_d;
  logic [DIV_W-1:0] hc_q, hc_d;
  logic             ph_q, ph_d;
  logic             act_q, act_d;

  always_comb begin
    sr_d  = sr_q;
    bi_d  = bi_q;
    hc_d  = hc_q;
    ph_d  = ph_q;
    act_d = act_q;
    if (load) begin
      sr_d  = din;
      bi_d  = '0;
      hc_d  = half_div;
      ph_d  = 1'b0;
      act_d = 1'b1;
    end else if (act_q) begin
      if (hc_q == '0) begin
        hc_d = half_div;
        if (!ph_q) begin
          ph_d = 1'b1;
        end else begin
          ph_d = 1'b0;
          sr_d = {1'b0, sr_q[7:1]};
          bi_d = bi_q + 3'd1;
          if (bi_q == 3'd7) act_d = 1'b0;
        end
      end else begin
        hc_d = hc_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      bi_q  <= '0;
      hc_q  <= '0;
      ph_q  <= 1'b0;
      act_q <= 1'b0;
    end else begin
      sr_q  <= sr_d;
      bi_q  <= bi_d;
      hc_q  <= hc_d;
      ph_q  <= ph_d;
      act_q <= act_d;
    end
  end

  assign sclk   = act_q & ph_q;
  assign sdat   = act_q & sr_q[0];
  assign active = act_q;
  assign last   = act_q & ph_q & (hc_q == '0) & (bi_q == 3'd7);

  // R6: data is held for the whole high phase of the clock
  p_dat_hold_high_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (sclk && $past(sclk)) |-> $stable(sdat));
  // R6: clock never rises in the same cycle the data moves
  p_dat_change_low_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (!$stable(sdat)) |-> !sclk);
endmodule

// File: rtl/ps_cfg_master.sv
module ps_cfg_master
  import ps_cfg_pkg::*;
#(
  parameter int CLK_MHZ      = 100,
  parameter int PULSE_US     = 5,
  parameter int DONE_US      = 10,
  parameter int STATUS_TO_US = 100,
  parameter int CNT_W        = 16,
  parameter int DIV_W        = 8,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] byte_total,
  input  logic [DIV_W-1:0] half_div,
  input  logic             s_valid,
  input  logic [7:0]       s_data,
  output logic             s_ready,
  output logic             cfg_req_n,
  output logic             cfg_clk,
  output logic             cfg_dat,
  input  logic             tgt_status,
  input  logic             tgt_done,
  output logic             busy,
  output logic             done,
  output logic             error
);
  localparam int PULSE_CYC = PULSE_US * CLK_MHZ;
  localparam int DONE_CYC  = DONE_US * CLK_MHZ;
  localparam int TO_CYC    = STATUS_TO_US * CLK_MHZ;
  localparam int MAX_A     = (PULSE_CYC > DONE_CYC) ? PULSE_CYC : DONE_CYC;
  localparam int MAX_CYC   = (MAX_A > TO_CYC) ? MAX_A : TO_CYC;
  localparam int TMR_W     = $clog2(MAX_CYC + 1);
  localparam logic [TMR_W-1:0] PULSE_V = TMR_W'(PULSE_CYC - 1);
  localparam logic [TMR_W-1:0] DONE_V  = TMR_W'(DONE_CYC - 1);
  localparam logic [TMR_W-1:0] TO_V    = TMR_W'(TO_CYC - 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  logic status_s, done_s;
  ps_sync #(.STAGES(SYNC_STAGES)) u_sync_status (
    .clk(clk), .rst_ni(rst_i), .d(tgt_status), .q(status_s));
  ps_sync #(.STAGES(SYNC_STAGES)) u_sync_done (
    .clk(clk), .rst_ni(rst_i), .d(tgt_done), .q(done_s));

  logic             tmr_ld, tmr_zero;
  logic [TMR_W-1:0] tmr_val;
  ps_us_timer #(.W(TMR_W)) u_timer (
    .clk(clk), .rst_ni(rst_i), .load(tmr_ld), .load_val(tmr_val), .zero(tmr_zero));

  cfg_state_e       st_q, st_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             done_q, done_d, err_q, err_d;
  logic             ser_ld, ser_last, ser_active;

  ps_bit_shifter #(.DIV_W(DIV_W)) u_shift (
    .clk(clk), .rst_ni(rst_i), .load(ser_ld), .din(s_data), .half_div(div_q),
    .sclk(cfg_clk), .sdat(cfg_dat), .active(ser_active), .last(ser_last));

  always_comb begin
    st_d    = st_q;
    rem_d   = rem_q;
    div_d   = div_q;
    done_d  = done_q;
    err_d   = err_q;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    ser_ld  = 1'b0;
    case (st_q)
      ST_IDLE: if (start) begin
        st_d    = ST_PULSE;
        rem_d   = byte_total;
        div_d   = half_div;
        done_d  = 1'b0;
        err_d   = 1'b0;
        tmr_ld  = 1'b1;
        tmr_val = PULSE_V;
      end
      ST_PULSE: if (tmr_zero) begin
        st_d    = ST_WAIT_ST;
        tmr_ld  = 1'b1;
        tmr_val = TO_V;
      end
      ST_WAIT_ST: begin
        if (status_s) begin
          if (rem_q == '0) begin
            st_d    = ST_WAIT_DONE;
            tmr_ld  = 1'b1;
            tmr_val = DONE_V;
          end else begin
            st_d = ST_LOAD;
          end
        end else if (tmr_zero) begin
          st_d  = ST_IDLE;
          err_d = 1'b1;
        end
      end
      ST_LOAD: if (s_valid) begin
        ser_ld = 1'b1;
        rem_d  = rem_q - 1'b1;
        st_d   = ST_SHIFT;
      end
      ST_SHIFT: if (ser_last) begin
        if (rem_q == '0) begin
          st_d    = ST_WAIT_DONE;
          tmr_ld  = 1'b1;
          tmr_val = DONE_V;
        end else begin
          st_d = ST_LOAD;
        end
      end
      ST_WAIT_DONE: if (tmr_zero) begin
        st_d = ST_IDLE;
        if (done_s) done_d = 1'b1;
        else        err_d  = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st_q   <= ST_IDLE;
      rem_q  <= '0;
      div_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      rem_q  <= rem_d;
      div_q  <= div_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign s_ready   = (st_q == ST_LOAD);
  assign cfg_req_n = (st_q != ST_PULSE);
  assign busy      = (st_q != ST_IDLE);
  assign done      = done_q;
  assign error     = err_q;

  // R2: no clock activity or byte request while the request line is low
  p_pulse_quiet_r2: assert property (@(posedge clk) disable iff (!rst_i)
    !cfg_req_n |-> (!cfg_clk && !s_ready && !ser_active));
  // R7: byte requested only with the clock parked low and the target released
  p_ready_parked_r7: assert property (@(posedge clk) disable iff (!rst_i)
    s_ready |-> (!cfg_clk && cfg_req_n && !ser_active));
  // R7: an accepted byte starts the serializer on the next cycle
  p_accept_shift_r7: assert property (@(posedge clk) disable iff (!rst_i)
    (s_valid && s_ready) |=> ser_active);
  // R4: a failure is only raised from one of the two waiting phases
  p_err_source_r4: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(error) |-> ($past(st_q) == ST_WAIT_ST || $past(st_q) == ST_WAIT_DONE));
  // R11: run flags are mutually exclusive
  p_flags_onehot_r11: assert property (@(posedge clk) disable iff (!rst_i)
    $onehot0({busy, done, error}));
endmodule

// File: tb/ps_cfg_master_bench.sv
module ps_cfg_master_bench;
  localparam int CLK_MHZ = 100, PULSE_US = 5, DONE_US = 10, TO_US = 20;
  localparam int PULSE_C = PULSE_US * CLK_MHZ;
  localparam int DONE_C  = DONE_US * CLK_MHZ;
  localparam int TO_C    = TO_US * CLK_MHZ;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [15:0] byte_total = '0;
  logic [7:0]  half_div = '0, s_data = '0;
  logic s_valid = 1'b0, tgt_status = 1'b0, tgt_done = 1'b0;
  logic s_ready, cfg_req_n, cfg_clk, cfg_dat, busy, done, error;

  ps_cfg_master #(.CLK_MHZ(CLK_MHZ), .PULSE_US(PULSE_US), .DONE_US(DONE_US),
    .STATUS_TO_US(TO_US), .CNT_W(16), .DIV_W(8), .SYNC_STAGES(2)) u_ps_cfg_master (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_total(byte_total),
    .half_div(half_div), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .cfg_req_n(cfg_req_n), .cfg_clk(cfg_clk), .cfg_dat(cfg_dat),
    .tgt_status(tgt_status), .tgt_done(tgt_done), .busy(busy), .done(done), .error(error));

  always #5 clk = ~clk;

  int tests = 0, fails = 0, prints = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      if (prints < 40) $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
      prints++;
    end
  endtask

  // ---- behavioural reference: a phase name and a few integer counters ----
  int m_st, m_t, m_rem, m_div, m_hc, m_ph, m_bit;
  logic [7:0] m_sr;
  bit m_done, m_err, m_s1, m_s2, m_d1, m_d2, m_r1, m_r2;
  bit hs;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_t = 0; m_rem = 0; m_div = 0; m_hc = 0; m_ph = 0; m_bit = 0; m_sr = 0;
      m_done = 0; m_err = 0; m_s1 = 0; m_s2 = 0; m_d1 = 0; m_d2 = 0; m_r1 = 0; m_r2 = 0;
      hs = 0;
    end else begin
      bit rel, st_seen, dn_seen;
      hs = s_valid && s_ready;
      rel = m_r2; m_r2 = m_r1; m_r1 = 1;
      if (rel) begin
        st_seen = m_s2; dn_seen = m_d2;
        m_s2 = m_s1; m_s1 = tgt_status; m_d2 = m_d1; m_d1 = tgt_done;
        if (m_t > 0 && (m_st == 1 || m_st == 2 || m_st == 5)) m_t = m_t - 1;
        else if (m_st == 1 || m_st == 2 || m_st == 5) m_t = -1;
        case (m_st)
          0: if (start) begin
               m_st = 1; m_t = PULSE_C - 1; m_rem = byte_total; m_div = half_div;
               m_done = 0; m_err = 0;
             end
          1: if (m_t < 0) begin m_st = 2; m_t = TO_C - 1; end
          2: if (st_seen) begin
               if (m_rem == 0) begin m_st = 5; m_t = DONE_C - 1; end else m_st = 3;
             end else if (m_t < 0) begin m_st = 0; m_err = 1; end
          3: if (s_valid) begin
               m_sr = s_data; m_bit = 0; m_ph = 0; m_hc = m_div; m_rem--; m_st = 4;
             end
          4: if (m_hc == 0) begin
               m_hc = m_div;
               if (m_ph == 0) m_ph = 1;
               else begin
                 m_ph = 0; m_sr = m_sr >> 1;
                 if (m_bit == 7) begin
                   if (m_rem == 0) begin m_st = 5; m_t = DONE_C - 1; end else m_st = 3;
                 end else m_bit++;
               end
             end else m_hc--;
          5: if (m_t < 0) begin m_st = 0; if (dn_seen) m_done = 1; else m_err = 1; end
          default: m_st = 0;
        endcase
      end
    end
  end

  // ---- target model: reassembles bytes on rising configuration clock ----
  logic [7:0] cap_sr = 0;
  int cap_bits = 0;
  logic [7:0] rx_q[$];
  always @(posedge cfg_clk) begin
    cap_sr = {cfg_dat, cap_sr[7:1]};
    cap_bits++;
    if (cap_bits % 8 == 0) rx_q.push_back(cap_sr);
  end

  // ---- stimulus side and per-cycle comparison, all on the falling edge ----
  logic [7:0] tx_q[$];
  int st_delay = -1, st_cnt = 0, low_cnt = 0, hi_run = 0, bad_hi = 0, hs_cnt = 0;
  int gap_ph = 0, cur_div = 0;
  bit gap_mode = 0;
  bit prev_clk = 0;

  always @(negedge clk) begin
    if (rst_n && m_r2) begin
      chk("R2 cfg_req_n", cfg_req_n, (m_st != 1));
      chk("R6 cfg_clk", cfg_clk, (m_st == 4 && m_ph == 1));
      chk("R5 cfg_dat", cfg_dat, (m_st == 4) ? m_sr[0] : 1'b0);
      chk("R7 s_ready", s_ready, (m_st == 3));
      chk("R10 busy", busy, (m_st != 0));
      chk("R8 done", done, m_done);
      chk("R8 error", error, m_err);
    end
    if (!cfg_req_n) begin low_cnt++; tgt_status = 0; st_cnt = 0; end
    else begin
      if (st_cnt == st_delay) tgt_status = 1;
      st_cnt++;
    end
    if (cfg_clk) hi_run++;
    else if (prev_clk) begin
      if (hi_run != cur_div + 1) bad_hi++;
      hi_run = 0;
    end
    prev_clk = cfg_clk;
    if (hs) begin void'(tx_q.pop_front()); hs_cnt++; hs = 0; end
    gap_ph++;
    s_valid = (tx_q.size() > 0) && !(gap_mode && (gap_ph % 3 != 0));
    s_data  = (tx_q.size() > 0) ? tx_q[0] : 8'h00;
  end

  task automatic run_cfg(input logic [7:0] bytes[$], input int total, input int div,
                         input int sdly, input bit dlvl, input bit gap, input bit exp_ok,
                         input int n_exp, input bit poke, input string tag);
    int cyc;
    rx_q.delete(); cap_bits = 0; low_cnt = 0; bad_hi = 0; hi_run = 0; hs_cnt = 0;
    tx_q = bytes; st_delay = sdly; tgt_done = dlvl; gap_mode = gap; cur_div = div;
    byte_total = 16'(total); half_div = 8'(div);
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    chk({"R11 flags cleared ", tag}, {done, error}, 2'b00);
    chk({"R2 busy on start ", tag}, busy, 1'b1);
    if (poke) begin
      repeat (PULSE_C + 100) @(negedge clk);
      start = 1;
      @(negedge clk) start = 0;
    end
    cyc = 0;
    while (busy && cyc < 60000) begin @(negedge clk); cyc++; end
    if (busy) begin
      fails++; tests++;
      $display("FAIL %s run hung act=busy exp=idle", tag);
    end
    chk({"R8/R4 result ", tag}, {done, error}, exp_ok ? 2'b10 : 2'b01);
    chk({"R2 pulse width ", tag}, low_cnt, PULSE_C);
    chk({"R5 bit count ", tag}, cap_bits, 8 * n_exp);
    chk({"R7 handshakes ", tag}, hs_cnt, n_exp);
    chk({"R6 high phase ", tag}, bad_hi, 0);
    chk({"R5 byte count ", tag}, rx_q.size(), n_exp);
    for (int i = 0; i < n_exp && i < rx_q.size(); i++)
      chk({"R5 byte value ", tag}, rx_q[i], bytes[i]);
    tx_q.delete();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset cfg_req_n", cfg_req_n, 1'b1);
    chk("R1 reset outputs", {cfg_clk, cfg_dat, s_ready, busy, done, error}, 6'b0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk("R1 idle cfg_req_n", cfg_req_n, 1'b1);
    chk("R1 idle outputs", {cfg_clk, cfg_dat, s_ready, busy, done, error}, 6'b0);

    run_cfg('{8'hA5, 8'h01, 8'h80}, 3, 1, 20, 1, 0, 1, 3, 0, "T1 R3");
    run_cfg('{8'h3C, 8'hFF}, 2, 0, 5, 0, 1, 0, 2, 0, "T2 R8 not-done");
    run_cfg('{8'h96}, 1, 3, 0, 1, 1, 1, 1, 0, "T3 R6 slow clk");
    run_cfg('{}, 2, 1, -1, 1, 0, 0, 0, 0, "T4 R4 timeout");
    run_cfg('{8'h5A}, 1, 1, TO_C - 3, 1, 0, 1, 1, 0, "T5 R3 ready on last cycle");
    run_cfg('{8'h5A}, 1, 1, TO_C - 2, 1, 0, 0, 0, 0, "T6 R4 ready one late");
    run_cfg('{}, 0, 1, 3, 1, 0, 1, 0, 0, "T7 R9 empty image");
    run_cfg('{8'h11, 8'h22, 8'h33}, 3, 2, 10, 1, 0, 1, 3, 1, "T8 R10 start mid-run");
    repeat (100) @(negedge clk);
    chk("R11 done holds while idle", {busy, done, error}, 3'b010);
    run_cfg('{8'hC3}, 1, 0, 2, 0, 1, 0, 1, 0, "T9 R11 flags switch");
    repeat (50) @(negedge clk);
    chk("R11 error holds while idle", {busy, done, error}, 3'b001);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule